// File: doc/BRIEF.md
# ROM Table Read Unit

This block lets a small microcontroller core read constant tables out of its 1024-word, 14-bit program ROM. The ROM has a single read port. Normally that port serves instruction fetch. When a table-read command arrives, the unit takes the port away from fetch for one cycle and puts a table address on it. It then returns the fetched word to the core in two parts.

The core selects one of two address modes. The current-page mode combines the two page bits of the program counter with an 8-bit table pointer, so a 256-word page can hold a table next to its code. The last-page mode combines a fixed all-ones page (page 3) with the same pointer, so any code can reach a shared table at the top of the ROM. The table pointer is a plain register that software writes. The low byte of the fetched word is written to the data-memory address carried by the command. The upper six bits are kept in a table-high register that can be read later.

Top module: `tblrd_unit`

## Requirements
- R1: After reset, tbl_ptr and tbl_hi are zero, and fetch_stall and dm_we are low.
- R2: When ptr_we is high at a clock edge, tbl_ptr takes ptr_wdata. Otherwise tbl_ptr keeps its value.
- R3: While no table read is in progress, fetch_stall is low and rom_addr equals fetch_pc.
- R4: A command accepted while idle (cmd_valid high at a clock edge) makes fetch_stall high for exactly the following cycle. During that cycle rom_addr carries the table address.
- R5: With cmd_last = 0 (current page), the table address is {fetch_pc[9:8], tbl_ptr}, both sampled at the accepting edge. A later change of fetch_pc has no effect on it.
- R6: With cmd_last = 1 (last page), the table address is {2'b11, tbl_ptr}, whatever value fetch_pc has.
- R7: In the stalled cycle, dm_we is high, dm_addr equals the cmd_dest sampled at acceptance, and dm_wdata equals rom_data[7:0]. In every other cycle dm_we is low.
- R8: At the end of the stalled cycle, tbl_hi loads rom_data[13:8]. It then holds that value until the next table read.
- R9: If cmd_valid is high during the stalled cycle, the command is ignored. No second stall and no second data-memory write follow.
- R10: If ptr_we and cmd_valid are high at the same edge, the read uses the pointer value from before the write. The register still takes the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_pc | input | 10 | Program counter that the fetch sequencer presents |
| ptr_we | input | 1 | Table pointer write strobe |
| ptr_wdata | input | 8 | New table pointer value from the data bus |
| cmd_valid | input | 1 | Table-read command strobe |
| cmd_last | input | 1 | Address mode: 0 = current page, 1 = last page |
| cmd_dest | input | 7 | Data-memory address that receives the low byte |
| rom_addr | output | 10 | Address on the shared ROM port |
| rom_data | input | 14 | ROM word for the address on rom_addr, available in the same cycle |
| fetch_stall | output | 1 | Holds instruction fetch for the cycle in which the ROM is borrowed |
| dm_we | output | 1 | Data-memory write strobe |
| dm_addr | output | 7 | Data-memory write address |
| dm_wdata | output | 8 | Data-memory write data (low byte of the ROM word) |
| tbl_ptr | output | 8 | Current table pointer |
| tbl_hi | output | 6 | Upper six bits of the last table word that was read |

## Verification
On every cycle, the assertions check the following. The stall lasts exactly one cycle. The data-memory strobe coincides with the stall. The written byte and the latched high bits match the ROM word on the port. The page bits follow the selected mode. The table-high register and the pointer change only when they should. Only the bench's scenarios can show the full address arithmetic against an independent ROM model. The bench sweeps every pointer value in both modes and across all four PC pages. It also covers the ordering cases where a pointer write, or a repeated command, lands on the same edge as the command or on the stall cycle.

// File: rtl/tblrd_pkg.sv
package tblrd_pkg;
  typedef enum logic {
    TR_CUR_PAGE  = 1'b0,
    TR_LAST_PAGE = 1'b1
  } tr_mode_e;

  typedef enum logic {
    SQ_IDLE = 1'b0,
    SQ_READ = 1'b1
  } sq_state_e;
endpackage

// File: rtl/tblrd_ptr_reg.sv
module tblrd_ptr_reg #(
  parameter int PTR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [PTR_W-1:0] wdata,
  output logic [PTR_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= wdata;
  end
endmodule

// File: rtl/tblrd_addr_gen.sv
module tblrd_addr_gen
  import tblrd_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int PTR_W  = 8,
  localparam int PAGE_W = ADDR_W - PTR_W
) (
  input  tr_mode_e          mode,
  input  logic [PAGE_W-1:0] pc_page,
  input  logic [PTR_W-1:0]  ptr,
  output logic [ADDR_W-1:0] addr
);
  // The page field comes from the PC, or it is forced to the top page.
  function automatic logic [ADDR_W-1:0] form_addr(
    input tr_mode_e          m,
    input logic [PAGE_W-1:0] pg,
    input logic [PTR_W-1:0]  p
  );
    logic [PAGE_W-1:0] sel_pg;
    sel_pg = (m == TR_LAST_PAGE) ? {PAGE_W{1'b1}} : pg;
    return {sel_pg, p};
  endfunction

  assign addr = form_addr(mode, pc_page, ptr);
endmodule

// File: rtl/tblrd_seq.sv
module tblrd_seq
  import tblrd_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DM_AW  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DM_AW-1:0]  dest_in,
  output logic              accept,
  output logic              busy,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DM_AW-1:0]  dest_q
);
  sq_state_e state_q, state_d;

  assign busy   = (state_q == SQ_READ);
  assign accept = cmd_valid && !busy;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SQ_IDLE: if (accept) state_d = SQ_READ;
      SQ_READ: state_d = SQ_IDLE;
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      addr_q  <= '0;
      dest_q  <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        addr_q <= addr_in;
        dest_q <= dest_in;
      end
    end
  end
endmodule

// File: rtl/tblrd_hi_reg.sv
module tblrd_hi_reg #(
  parameter int HI_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [HI_W-1:0] d,
  output logic [HI_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/tblrd_unit.sv
module tblrd_unit
  import tblrd_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int WORD_W = 14,
  parameter int PTR_W  = 8,
  parameter int DM_AW  = 7,
  localparam int PAGE_W = ADDR_W - PTR_W,
  localparam int HI_W   = WORD_W - PTR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] fetch_pc,
  input  logic              ptr_we,
  input  logic [PTR_W-1:0]  ptr_wdata,
  input  logic              cmd_valid,
  input  logic              cmd_last,
  input  logic [DM_AW-1:0]  cmd_dest,
  output logic [ADDR_W-1:0] rom_addr,
  input  logic [WORD_W-1:0] rom_data,
  output logic              fetch_stall,
  output logic              dm_we,
  output logic [DM_AW-1:0]  dm_addr,
  output logic [PTR_W-1:0]  dm_wdata,
  output logic [PTR_W-1:0]  tbl_ptr,
  output logic [HI_W-1:0]   tbl_hi
);
  // Internal events, named so that the checker can see them
  logic              accept_evt;
  logic              read_cycle;
  logic [ADDR_W-1:0] tbl_addr_now;
  logic [ADDR_W-1:0] tbl_addr_q;
  logic [DM_AW-1:0]  dest_q;

  tblrd_ptr_reg #(.PTR_W(PTR_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .we(ptr_we), .wdata(ptr_wdata), .q(tbl_ptr)
  );

  tblrd_addr_gen #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_agen (
    .mode    (tr_mode_e'(cmd_last)),
    .pc_page (fetch_pc[ADDR_W-1 -: PAGE_W]),
    .ptr     (tbl_ptr),
    .addr    (tbl_addr_now)
  );

  tblrd_seq #(.ADDR_W(ADDR_W), .DM_AW(DM_AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid),
    .addr_in(tbl_addr_now), .dest_in(cmd_dest),
    .accept(accept_evt), .busy(read_cycle),
    .addr_q(tbl_addr_q), .dest_q(dest_q)
  );

  tblrd_hi_reg #(.HI_W(HI_W)) u_hi (
    .clk(clk), .rst_n(rst_n), .load(read_cycle),
    .d(rom_data[WORD_W-1 -: HI_W]), .q(tbl_hi)
  );

  assign rom_addr    = read_cycle ? tbl_addr_q : fetch_pc;
  assign fetch_stall = read_cycle;
  assign dm_we       = read_cycle;
  assign dm_addr     = dest_q;
  assign dm_wdata    = rom_data[PTR_W-1:0];
endmodule

// File: rtl/tblrd_unit_chk.sv
module tblrd_unit_chk #(
  parameter int ADDR_W = 10,
  parameter int WORD_W = 14,
  parameter int PTR_W  = 8,
  parameter int DM_AW  = 7,
  localparam int PAGE_W = ADDR_W - PTR_W,
  localparam int HI_W   = WORD_W - PTR_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] fetch_pc,
  input logic              ptr_we,
  input logic [PTR_W-1:0]  ptr_wdata,
  input logic              cmd_last,
  input logic              accept_evt,
  input logic [ADDR_W-1:0] rom_addr,
  input logic [WORD_W-1:0] rom_data,
  input logic              fetch_stall,
  input logic              dm_we,
  input logic [PTR_W-1:0]  dm_wdata,
  input logic [PTR_W-1:0]  tbl_ptr,
  input logic [HI_W-1:0]   tbl_hi
);
  p_ptr_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_we |=> tbl_ptr == $past(ptr_wdata));

  p_ptr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ptr_we |=> $stable(tbl_ptr));

  p_idle_port_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_stall |-> rom_addr == fetch_pc);

  p_accept_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> fetch_stall);

  p_single_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_stall |=> !fetch_stall);

  p_cur_page_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_evt && !cmd_last) |=>
      rom_addr[ADDR_W-1 -: PAGE_W] == $past(fetch_pc[ADDR_W-1 -: PAGE_W]));

  p_last_page_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_evt && cmd_last) |=> rom_addr[ADDR_W-1 -: PAGE_W] == {PAGE_W{1'b1}});

  p_dm_with_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dm_we == fetch_stall);

  p_dm_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dm_we |-> dm_wdata == rom_data[PTR_W-1:0]);

  p_hi_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dm_we |=> tbl_hi == $past(rom_data[WORD_W-1 -: HI_W]));

  p_hi_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !dm_we |=> $stable(tbl_hi));
endmodule

bind tblrd_unit tblrd_unit_chk #(
  .ADDR_W(ADDR_W), .WORD_W(WORD_W), .PTR_W(PTR_W), .DM_AW(DM_AW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .ptr_we(ptr_we),
  .ptr_wdata(ptr_wdata), .cmd_last(cmd_last), .accept_evt(accept_evt),
  .rom_addr(rom_addr), .rom_data(rom_data), .fetch_stall(fetch_stall),
  .dm_we(dm_we), .dm_wdata(dm_wdata), .tbl_ptr(tbl_ptr), .tbl_hi(tbl_hi)
);

// File: tb/tb_tblrd_unit.sv
module tb_tblrd_unit;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] fetch_pc = '0;
  logic       ptr_we = 1'b0;
  logic [7:0] ptr_wdata = '0;
  logic       cmd_valid = 1'b0;
  logic       cmd_last = 1'b0;
  logic [6:0] cmd_dest = '0;
  logic [9:0] rom_addr;
  logic [13:0] rom_data;
  logic       fetch_stall, dm_we;
  logic [6:0] dm_addr;
  logic [7:0] dm_wdata, tbl_ptr;
  logic [5:0] tbl_hi;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Independent ROM model: an arithmetic word for each address
  function automatic logic [13:0] rom_fn(input logic [9:0] a);
    logic [13:0] w;
    w = ({4'b0, a} * 14'd73) ^ {a, 4'b0} ^ 14'h2A5;
    return w;
  endfunction

  assign rom_data = rom_fn(rom_addr);

  tblrd_unit dut (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .ptr_we(ptr_we),
    .ptr_wdata(ptr_wdata), .cmd_valid(cmd_valid), .cmd_last(cmd_last),
    .cmd_dest(cmd_dest), .rom_addr(rom_addr), .rom_data(rom_data),
    .fetch_stall(fetch_stall), .dm_we(dm_we), .dm_addr(dm_addr),
    .dm_wdata(dm_wdata), .tbl_ptr(tbl_ptr), .tbl_hi(tbl_hi)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // One full table read with pointer load first; PC page changes during the stall
  task automatic do_read(input logic last, input logic [1:0] page,
                         input logic [7:0] ptr, input logic [6:0] dest);
    logic [9:0]  exp_addr;
    logic [13:0] w;
    @(negedge clk);
    ptr_we = 1'b1; ptr_wdata = ptr;
    fetch_pc = {page, ptr ^ 8'h5C};
    @(negedge clk);
    ptr_we = 1'b0;
    chk("R2 pointer load", tbl_ptr, ptr);
    chk("R3 idle port", rom_addr, fetch_pc);
    cmd_valid = 1'b1; cmd_last = last; cmd_dest = dest;
    exp_addr = last ? {2'b11, ptr} : {page, ptr};
    w = rom_fn(exp_addr);
    @(negedge clk);
    cmd_valid = 1'b0;
    fetch_pc = {page ^ 2'b01, 8'h00};
    chk("R4 stall", fetch_stall, 1'b1);
    chk(last ? "R6 last-page addr" : "R5 cur-page addr", rom_addr, exp_addr);
    chk("R7 dm write", {dm_we, dm_addr, dm_wdata}, {1'b1, dest, w[7:0]});
    @(negedge clk);
    chk("R4 stall ends", fetch_stall, 1'b0);
    chk("R7 dm idle", dm_we, 1'b0);
    chk("R8 tbl_hi", tbl_hi, w[13:8]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [13:0] w;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 tbl_ptr", tbl_ptr, 8'h00);
    chk("R1 tbl_hi", tbl_hi, 6'h00);
    chk("R1 stall", fetch_stall, 1'b0);
    chk("R1 dm_we", dm_we, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    fetch_pc = 10'h2F3;
    #1 chk("R3 idle port follows pc", rom_addr, 10'h2F3);

    // Sweeps over every pointer: last page, then each current page
    for (int p = 0; p < 256; p++)
      do_read(1'b1, 2'(p % 4), 8'(p), 7'(p * 3));
    for (int pg = 0; pg < 4; pg++)
      for (int p = 0; p < 256; p++)
        do_read(1'b0, 2'(pg), 8'(p), 7'(p + pg));

    // R8 hold and R2 hold: idle cycles keep tbl_hi and tbl_ptr
    w = rom_fn({2'b11, 8'hFF});
    do_read(1'b1, 2'b00, 8'hFF, 7'h10);
    repeat (3) @(negedge clk);
    chk("R8 tbl_hi holds", tbl_hi, w[13:8]);
    chk("R2 pointer holds", tbl_ptr, 8'hFF);

    // R9: command held high across the stall cycle is accepted once
    @(negedge clk);
    ptr_we = 1'b1; ptr_wdata = 8'h3A;
    @(negedge clk);
    ptr_we = 1'b0; fetch_pc = 10'h100;
    cmd_valid = 1'b1; cmd_last = 1'b0; cmd_dest = 7'h22;
    @(negedge clk);
    chk("R9 first stall", fetch_stall, 1'b1);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R9 no second stall", fetch_stall, 1'b0);
    chk("R9 no second write", dm_we, 1'b0);
    chk("R9 port back to pc", rom_addr, 10'h100);

    // R10: pointer write on the accepting edge uses the old pointer
    @(negedge clk);
    fetch_pc = 10'h2AA;
    ptr_we = 1'b1; ptr_wdata = 8'hC5;
    cmd_valid = 1'b1; cmd_last = 1'b0; cmd_dest = 7'h05;
    w = rom_fn({2'b10, 8'h3A});
    @(negedge clk);
    ptr_we = 1'b0; cmd_valid = 1'b0;
    chk("R10 old pointer used", rom_addr, {2'b10, 8'h3A});
    chk("R10 byte from old address", dm_wdata, w[7:0]);
    chk("R10 pointer updated", tbl_ptr, 8'hC5);
    @(negedge clk);
    chk("R10 tbl_hi from old address", tbl_hi, w[13:8]);

    // R10 variant: pointer write during the stall leaves the read untouched
    @(negedge clk);
    cmd_valid = 1'b1; cmd_last = 1'b1; cmd_dest = 7'h7F;
    @(negedge clk);
    cmd_valid = 1'b0; ptr_we = 1'b1; ptr_wdata = 8'h01;
    chk("R10 stall addr keeps pointer", rom_addr, {2'b11, 8'hC5});
    chk("R7 dest at edge", dm_addr, 7'h7F);
    @(negedge clk);
    ptr_we = 1'b0;
    chk("R2 write in stall lands", tbl_ptr, 8'h01);

    finish_run();
  end
endmodule